// File: doc/BRIEF.md
# LED Matrix Dot Fault Monitor

This block runs a single-shot open test or short test over a multiplexed LED matrix and keeps one fault bit for every dot. Testing starts when a two-bit detect-mode field changes to an active code. The block then steps through the matrix rows one at a time. It tells external comparators which row to probe and which kind of test to run. On the last cycle a row is held, it captures that row's per-column fault flags.

The results are readable as bytes in a sparse window. Each row owns four bytes followed by one unused gap byte. A two-bit status byte records that an open or a short was found. An active-low interrupt line reports a finished test that found faults, when the interrupt mask enables that kind of test. Reading the status clears it and releases the line. Optionally, the line also releases by itself once it has been low for longer than a programmed time.

Top module: `dot_fault_monitor`

## Requirements
- R1: Mode code 2'b01 starts an open test and code 2'b10 starts a short test; `scan_short` shows the running kind (1 = short) while `scan_busy` is high.
- R2: Mode codes 2'b00 and 2'b11 never start a test.
- R3: A test starts at most once per arming. Arming happens while the mode reads 2'b00. Holding an active code, or switching directly between the two active codes, starts nothing new.
- R4: Starting a test clears every stored fault bit before the new row results are written.
- R5: Within a row group, byte 0 holds columns 8..1, byte 1 holds columns 16..9 and byte 2 holds columns 24..17, with the higher column in the higher bit. Byte 3 holds columns 30..25 in bits 5..0 and reads zero in bits 7..6.
- R6: Row r (0..5) starts at address 3 + 5*r. The fifth byte of each group, and every address outside 0x03..0x20, reads zero. All fault bytes read zero after reset.
- R7: Status bit 0 is set when an open test ends with any fault and bit 1 when a short test ends with any fault; bits 7..2 read zero. A test with no fault leaves the status unchanged.
- R8: `irq_n` goes low when a test ends with any fault and the matching mask bit is 1 (mask bit 0 for open, bit 1 for short); otherwise it stays high.
- R9: A one-cycle `stat_rd` pulse clears both status bits and drives `irq_n` high.
- R10: With mask bit 4 set, `irq_n` returns high after staying low for CLK_KHZ*AUTOCLR_MS+1 cycles, and the status bits stay set. With bit 4 clear, the line stays low until the status is read.
- R11: A test visits rows 0 to ROWS-1 in order, holds each for ROW_CYCLES cycles, and keeps `scan_busy` high for exactly ROWS*ROW_CYCLES cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_mode | input | 2 | Detect-mode field: 00/11 idle, 01 open, 10 short |
| int_mask | input | 8 | Bit 0 open interrupt, bit 1 short interrupt, bit 4 auto-release |
| stat_rd | input | 1 | Status read strobe, one cycle |
| flt_bits | input | COLS | Comparator fault flags for the row on `scan_row` |
| scan_busy | output | 1 | Test in progress |
| scan_row | output | $clog2(ROWS) | Row being probed |
| scan_short | output | 1 | Kind of running test, 1 = short |
| rd_addr | input | 8 | Fault byte address |
| rd_data | output | 8 | Fault byte at `rd_addr` |
| stat_byte | output | 8 | Status: bit 0 open found, bit 1 short found |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Several fault patterns are applied: sparse random patterns, a single fault in column 1, a single fault in column 30, and an all-clear pattern. Together they tell the byte packing and gap decoding apart from row misplacement, and they show whether an empty test wrongly raises status. Mode sequences (holding a code, switching directly between active codes, using 11, and re-arming through 00) separate one-shot triggering from level triggering. Mask combinations, read strobes and a long wait with auto-release enabled show that status, interrupt line and release timer are independent of one another.

// File: rtl/dfm_pkg.sv
package dfm_pkg;

   typedef enum logic [1:0] {
      MODE_IDLE  = 2'b00,
      MODE_OPEN  = 2'b01,
      MODE_SHORT = 2'b10,
      MODE_HOLD  = 2'b11
   } det_mode_e;

   localparam int MASK_OPEN_BIT  = 0;
   localparam int MASK_SHORT_BIT = 1;
   localparam int MASK_AUTO_BIT  = 4;

   function automatic logic is_active(input logic [1:0] code);
      return (code == MODE_OPEN) || (code == MODE_SHORT);
   endfunction

   function automatic int bytes_per_row(input int cols);
      return (cols + 7) / 8;
   endfunction

endpackage

// File: rtl/dfm_seq.sv
module dfm_seq
   import dfm_pkg::*;
#(
   parameter int ROWS       = 6,
   parameter int ROW_CYCLES = 4,
   localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
   localparam int CW = (ROW_CYCLES > 1) ? $clog2(ROW_CYCLES) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    det_mode,
   output logic          busy,
   output logic [RW-1:0] row,
   output logic          is_short,
   output logic          start,
   output logic          sample,
   output logic          done
);

   logic          armed_q;
   logic          busy_q;
   logic [RW-1:0] row_q;
   logic          short_q;
   logic          last_cyc;

   assign start  = !busy_q && armed_q && is_active(det_mode);
   assign sample = busy_q && last_cyc;
   assign done   = sample && (row_q == RW'(ROWS - 1));

   generate
      if (ROW_CYCLES == 1) begin : g_single
         assign last_cyc = 1'b1;
      end else begin : g_multi
         logic [CW-1:0] cyc_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                cyc_q <= '0;
            else if (start || sample)  cyc_q <= '0;
            else if (busy_q)           cyc_q <= cyc_q + 1'b1;
         end
         assign last_cyc = (cyc_q == CW'(ROW_CYCLES - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b1;
         busy_q  <= 1'b0;
         row_q   <= '0;
         short_q <= 1'b0;
      end else begin
         if (det_mode == MODE_IDLE) armed_q <= 1'b1;
         else if (start)            armed_q <= 1'b0;
         if (start) begin
            busy_q  <= 1'b1;
            row_q   <= '0;
            short_q <= (det_mode == MODE_SHORT);
         end else if (done) begin
            busy_q  <= 1'b0;
            row_q   <= '0;
         end else if (sample) begin
            row_q   <= row_q + 1'b1;
         end
      end
   end

   assign busy     = busy_q;
   assign row      = row_q;
   assign is_short = short_q;

   // R2 R3
   start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> is_active($past(det_mode)));

   // R11
   row_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (row_q <= RW'(ROWS - 1)));

   // R11
   row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q) && !$past(sample)) |-> $stable(row_q));

endmodule

// File: rtl/dfm_store.sv
module dfm_store
   import dfm_pkg::*;
#(
   parameter int ROWS     = 6,
   parameter int COLS     = 30,
   parameter int BASE_OFS = 3,
   localparam int RW     = (ROWS > 1) ? $clog2(ROWS) : 1,
   localparam int NB     = bytes_per_row(COLS),
   localparam int STRIDE = NB + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            wr_en,
   input  logic [RW-1:0]   wr_row,
   input  logic [COLS-1:0] wr_bits,
   input  logic [7:0]      rd_addr,
   output logic [7:0]      rd_data,
   output logic            any_set
);

   logic [COLS-1:0] mem  [ROWS];
   logic [NB*8-1:0] wide [ROWS];

   generate
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                 mem[r] <= '0;
            else if (clear)                             mem[r] <= '0;
            else if (wr_en && (wr_row == RW'(r)))       mem[r] <= wr_bits;
         end
         assign wide[r] = (NB*8)'(mem[r]);
      end
   endgenerate

   always_comb begin
      rd_data = 8'h00;
      for (int r = 0; r < ROWS; r++) begin
         for (int b = 0; b < NB; b++) begin
            if (rd_addr == 8'(BASE_OFS + r*STRIDE + b))
               rd_data = wide[r][b*8 +: 8];
         end
      end
   end

   always_comb begin
      any_set = 1'b0;
      for (int r = 0; r < ROWS; r++) any_set = any_set | (|mem[r]);
   end

   // R4
   clear_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |-> !wr_en);

   // R11
   wr_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_row <= RW'(ROWS - 1)));

endmodule

// File: rtl/dfm_irq.sv
module dfm_irq #(
   parameter int AC_LIMIT = 800,
   localparam int ACW = $clog2(AC_LIMIT + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       done,
   input  logic       done_short,
   input  logic       hit,
   input  logic       en_open,
   input  logic       en_short,
   input  logic       en_auto,
   input  logic       stat_rd,
   output logic [1:0] status,
   output logic       irq_n
);

   logic [1:0]     stat_q;
   logic           act_q;
   logic [ACW-1:0] cnt_q;
   logic           found;
   logic           fire;

   assign found = done && hit;
   assign fire  = found && (done_short ? en_short : en_open);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= 2'b00;
      end else begin
         if (found)        stat_q[done_short] <= 1'b1;
         if (stat_rd) begin
            stat_q <= 2'b00;
            if (found)     stat_q[done_short] <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         cnt_q <= '0;
      end else if (fire) begin
         act_q <= 1'b1;
         cnt_q <= '0;
      end else if (stat_rd) begin
         act_q <= 1'b0;
         cnt_q <= '0;
      end else if (act_q && en_auto) begin
         if (cnt_q == ACW'(AC_LIMIT)) begin
            act_q <= 1'b0;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign status = stat_q;
   assign irq_n  = !act_q;

   // R9
   read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !done) |=> (status == 2'b00 && irq_n));

   // R8
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_n) |-> $past(found));

   // R10
   hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && !en_auto && !stat_rd) |=> !irq_n);

   // R10
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= ACW'(AC_LIMIT));

endmodule

// File: rtl/dot_fault_monitor.sv
module dot_fault_monitor
   import dfm_pkg::*;
#(
   parameter int ROWS       = 6,
   parameter int COLS       = 30,
   parameter int ROW_CYCLES = 4,
   parameter int BASE_OFS   = 3,
   parameter int CLK_KHZ    = 100,
   parameter int AUTOCLR_MS = 8,
   localparam int RW       = (ROWS > 1) ? $clog2(ROWS) : 1,
   localparam int AC_LIMIT = CLK_KHZ * AUTOCLR_MS
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      det_mode,
   input  logic [7:0]      int_mask,
   input  logic            stat_rd,
   input  logic [COLS-1:0] flt_bits,
   output logic            scan_busy,
   output logic [RW-1:0]   scan_row,
   output logic            scan_short,
   input  logic [7:0]      rd_addr,
   output logic [7:0]      rd_data,
   output logic [7:0]      stat_byte,
   output logic            irq_n
);

   localparam int NB     = bytes_per_row(COLS);
   localparam int STRIDE = NB + 1;

   generate
      if (COLS < 1 || COLS > 32) begin : g_bad_cols
         $fatal(1, "COLS must lie in 1..32");
      end
      if (ROWS < 2) begin : g_bad_rows
         $fatal(1, "ROWS must be at least 2");
      end
      if (ROW_CYCLES < 1) begin : g_bad_cyc
         $fatal(1, "ROW_CYCLES must be at least 1");
      end
      if (BASE_OFS + ROWS*STRIDE > 256) begin : g_bad_map
         $fatal(1, "fault window exceeds the byte address space");
      end
      if (AC_LIMIT < 1) begin : g_bad_ac
         $fatal(1, "auto-release time must be nonzero");
      end
   endgenerate

   logic          start, sample, done, busy, is_short, any_set;
   logic [RW-1:0] row;
   logic [1:0]    status;
   logic          unused_mask;

   assign unused_mask = ^{int_mask[7:5], int_mask[3:2]};

   dfm_seq #(.ROWS(ROWS), .ROW_CYCLES(ROW_CYCLES)) u_seq (
      .clk(clk), .rst_n(rst_n), .det_mode(det_mode),
      .busy(busy), .row(row), .is_short(is_short),
      .start(start), .sample(sample), .done(done)
   );

   dfm_store #(.ROWS(ROWS), .COLS(COLS), .BASE_OFS(BASE_OFS)) u_store (
      .clk(clk), .rst_n(rst_n), .clear(start),
      .wr_en(sample), .wr_row(row), .wr_bits(flt_bits),
      .rd_addr(rd_addr), .rd_data(rd_data), .any_set(any_set)
   );

   dfm_irq #(.AC_LIMIT(AC_LIMIT)) u_irq (
      .clk(clk), .rst_n(rst_n), .done(done), .done_short(is_short),
      .hit(any_set | (|flt_bits)),
      .en_open(int_mask[MASK_OPEN_BIT]), .en_short(int_mask[MASK_SHORT_BIT]),
      .en_auto(int_mask[MASK_AUTO_BIT]), .stat_rd(stat_rd),
      .status(status), .irq_n(irq_n)
   );

   assign scan_busy  = busy;
   assign scan_row   = row;
   assign scan_short = is_short;
   assign stat_byte  = {6'b000000, status};

   // R7
   stat_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_byte[1:0] != 2'b00 && $past(stat_byte[1:0]) == 2'b00) |-> $past(done));

   // R1
   kind_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_busy && $past(scan_busy)) |-> $stable(scan_short));

endmodule

// File: tb/tb_dot_fault_monitor.sv
module tb_dot_fault_monitor;

   localparam int CLK_PERIOD = 10;
   localparam int ROWS  = 6;
   localparam int COLS  = 30;
   localparam int RCYC  = 4;
   localparam int LIMIT = 100 * 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [1:0]      det_mode = 2'b00;
   logic [7:0]      int_mask = 8'h00;
   logic            stat_rd = 1'b0;
   logic [COLS-1:0] flt_bits = '0;
   logic            scan_busy;
   logic [2:0]      scan_row;
   logic            scan_short;
   logic [7:0]      rd_addr = 8'h00;
   logic [7:0]      rd_data;
   logic [7:0]      stat_byte;
   logic            irq_n;

   int n_chk = 0;
   int n_bad = 0;

   logic [COLS-1:0] pat   [ROWS];
   logic [COLS-1:0] model [ROWS];

   always #(CLK_PERIOD/2) clk = ~clk;

   dot_fault_monitor dut (
      .clk(clk), .rst_n(rst_n), .det_mode(det_mode), .int_mask(int_mask),
      .stat_rd(stat_rd), .flt_bits(flt_bits), .scan_busy(scan_busy),
      .scan_row(scan_row), .scan_short(scan_short), .rd_addr(rd_addr),
      .rd_data(rd_data), .stat_byte(stat_byte), .irq_n(irq_n)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_byte(input int a);
      logic [7:0] v;
      v = 8'h00;
      for (int r = 0; r < ROWS; r++) begin
         if (a == 3 + 5*r)     v = model[r][7:0];
         if (a == 3 + 5*r + 1) v = model[r][15:8];
         if (a == 3 + 5*r + 2) v = model[r][23:16];
         if (a == 3 + 5*r + 3) v = {2'b00, model[r][29:24]};
      end
      return v;
   endfunction

   function automatic logic pat_hit();
      logic h;
      h = 1'b0;
      for (int r = 0; r < ROWS; r++) h = h | (|pat[r]);
      return h;
   endfunction

   task automatic check_bytes(input string req);
      for (int a = 0; a < 40; a++) begin
         @(negedge clk);
         rd_addr = 8'(a);
         #1;
         chk(req, {24'h0, rd_data}, {24'h0, exp_byte(a)});
      end
   endtask

   task automatic set_mode(input logic [1:0] m);
      @(negedge clk);
      det_mode = m;
   endtask

   // drives the comparator flags for the row on scan_row; returns busy cycles
   task automatic run_scan(input logic [1:0] code, output int cycles);
      int guard;
      set_mode(code);
      cycles = 0;
      guard = 0;
      @(negedge clk);
      while (scan_busy && guard < 1000) begin
         flt_bits = pat[scan_row];
         chk("R1 kind", {31'h0, scan_short}, {31'h0, code == 2'b10});
         cycles++;
         guard++;
         @(negedge clk);
      end
      flt_bits = '0;
      for (int r = 0; r < ROWS; r++) model[r] = pat[r];
   endtask

   task automatic pulse_read();
      @(negedge clk);
      stat_rd = 1'b1;
      @(negedge clk);
      stat_rd = 1'b0;
      chk("R9 status cleared", {24'h0, stat_byte}, 32'h0);
      chk("R9 irq released", {31'h0, irq_n}, 32'h1);
   endtask

   task automatic idle_watch(input int n, input string req);
      int seen;
      seen = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (scan_busy) seen++;
      end
      chk(req, 32'(seen), 32'h0);
   endtask

   initial begin
      int cyc;
      logic [1:0] code;
      logic [7:0] st_exp;
      logic exp_irq;
      void'($urandom(32'd2024));
      for (int r = 0; r < ROWS; r++) begin pat[r] = '0; model[r] = '0; end

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("reset irq", {31'h0, irq_n}, 32'h1);
      chk("R7 reset status", {24'h0, stat_byte}, 32'h0);
      chk("reset idle", {31'h0, scan_busy}, 32'h0);
      check_bytes("R6 reset bytes");

      // open test, single faults at column 1 and column 30 plus a sparse row
      int_mask = 8'h01;
      pat[0] = 30'h0000_0001;
      pat[2] = 30'h2000_0000;
      pat[5] = 30'h1234_5678 & 30'h3FFF_FFFF;
      run_scan(2'b01, cyc);
      chk("R11 scan length", 32'(cyc), 32'(ROWS*RCYC));
      chk("R7 open status", {24'h0, stat_byte}, 32'h1);
      chk("R8 open irq", {31'h0, irq_n}, 32'h0);
      check_bytes("R5 R6 open bytes");

      // holding the code or switching directly between active codes starts nothing
      idle_watch(20, "R3 held code");
      set_mode(2'b10);
      idle_watch(20, "R3 direct switch");
      pulse_read();

      // 11 never starts; re-arm through 00 then short test with new pattern
      set_mode(2'b00);
      set_mode(2'b11);
      idle_watch(20, "R2 code 11");
      set_mode(2'b00);
      idle_watch(5, "R2 code 00");
      int_mask = 8'h02;
      for (int r = 0; r < ROWS; r++) pat[r] = '0;
      pat[1] = 30'h0000_8100;
      run_scan(2'b10, cyc);
      chk("R11 scan length short", 32'(cyc), 32'(ROWS*RCYC));
      chk("R7 short status", {24'h0, stat_byte}, 32'h2);
      chk("R8 short irq", {31'h0, irq_n}, 32'h0);
      check_bytes("R4 old faults cleared");
      pulse_read();

      // masked: status set, line stays high
      set_mode(2'b00);
      int_mask = 8'h02;
      pat[3] = 30'h0000_0004;
      run_scan(2'b01, cyc);
      chk("R7 masked status", {24'h0, stat_byte}, 32'h1);
      chk("R8 masked irq", {31'h0, irq_n}, 32'h1);
      pulse_read();

      // all-clear pattern: no status, no interrupt
      set_mode(2'b00);
      int_mask = 8'h03;
      for (int r = 0; r < ROWS; r++) pat[r] = '0;
      run_scan(2'b10, cyc);
      chk("R7 no-fault status", {24'h0, stat_byte}, 32'h0);
      chk("R8 no-fault irq", {31'h0, irq_n}, 32'h1);
      check_bytes("R4 empty storage");

      // auto-release
      set_mode(2'b00);
      int_mask = 8'h11;
      pat[4] = 30'h0100_0000;
      run_scan(2'b01, cyc);
      chk("R10 low at start", {31'h0, irq_n}, 32'h0);
      repeat (LIMIT) @(negedge clk);
      chk("R10 low at limit", {31'h0, irq_n}, 32'h0);
      @(negedge clk);
      chk("R10 released", {31'h0, irq_n}, 32'h1);
      chk("R10 status kept", {24'h0, stat_byte}, 32'h1);
      pulse_read();

      // random patterns
      for (int it = 0; it < 10; it++) begin
         set_mode(2'b00);
         @(negedge clk);
         code = ($urandom % 2) ? 2'b10 : 2'b01;
         int_mask = 8'($urandom) & 8'h03;
         for (int r = 0; r < ROWS; r++)
            pat[r] = (it % 4 == 3) ? '0 : COLS'($urandom & $urandom & $urandom);
         run_scan(code, cyc);
         st_exp  = pat_hit() ? ((code == 2'b10) ? 8'h02 : 8'h01) : 8'h00;
         exp_irq = pat_hit() && int_mask[(code == 2'b10) ? 1 : 0];
         chk("R11 random length", 32'(cyc), 32'(ROWS*RCYC));
         chk("R7 random status", {24'h0, stat_byte}, {24'h0, st_exp});
         chk("R8 random irq", {31'h0, irq_n}, {31'h0, !exp_irq});
         check_bytes("R5 random bytes");
         pulse_read();
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule